// File: doc/BRIEF.md
# Coherence Request Issue Scheduler

This block is the entry stage of a directory controller for a shared last-level cache. Three sources compete to enter the controller's pipeline: a local queue of eviction (replacement) messages, the response port of the on-chip network, and the request port of the same network. Each source has its own admission rule. These rules depend on the occupancy of the pending-transaction table, on that table's per-source lookup results, on the busy flags of the later stages, on whether both network output channels can accept traffic, and on a stall flag supplied by the protocol table.

In any cycle the block picks at most one admissible source by fixed priority. The order is eviction first, then response, then request. The block raises a one-hot grant and the matching dequeue strobe in the same cycle. It also splits each source's address into a tag and a set index, one lookup port per source, for the pending-transaction table. The winning message is captured, together with its lookup result, into the stage-2 pipeline register.

Top module: `coh_issue_sched`

## Requirements
- R1: After reset `s2_valid` is 0, and with no source presenting work `grant` is 3'b000.
- R2: An eviction is admissible only when all of these hold: `rq_empty` is 0, `tbl_full` is 0, `rq_lk_hit` is 0, the pipeline is not occupied (see R9), and both `fwd_net_ready` and `rsp_net_ready` are 1.
- R3: A network request is admissible only when all of these hold: `req_valid` is 1, `tbl_full` is 0, the pipeline is not occupied (see R9), and both network outputs are ready.
- R4: A network request must also meet one of three conditions: it misses in the table (`req_lk_hit`=0), or it hits an entry whose valid bit is clear (`req_lk_entry_valid`=0), or it hits a valid entry while `proto_stall` is 0.
- R5: A network response is admissible whenever `rsp_valid` is 1. Table fullness, busy flags, readiness and stall have no effect on it.
- R6: When several sources are admissible, the grant order is eviction, then response, then request. The grant bit positions are 0 for eviction, 1 for response and 2 for request.
- R7: `grant` is one-hot or zero, and it is zero when nothing is admissible. Each dequeue strobe (`rq_pop`, `rsp_pop`, `req_pop`) equals its grant bit in the same cycle.
- R8: One cycle after a grant, `s2_valid` is 1. `s2_src` then holds the source code (0 eviction, 1 response, 2 request), and `s2_addr`, `s2_kind` and `s2_origin` hold the winner's fields (kind and origin are 0 for an eviction). After a cycle with no grant, `s2_valid` is 0 and every stage-2 field is 0.
- R9: Only one message occupies the pipeline. While `s2_valid`, `s2_busy` or `s3_busy` is 1, no eviction or request is granted.
- R10: Each lookup port carries its source's address split into fields: the tag is address bits [15:10] and the set is bits [9:4] (defaults: 16-bit address, 4 offset bits, 6 set bits).
- R11: A lookup result counts only when its port's hit flag is set. `s2_tbl_hit` is the winner's hit flag, and `s2_tbl_idx` is the winner's lookup index when that flag is 1 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_empty | input | 1 | Eviction queue holds nothing |
| rq_addr | input | 16 | Address at eviction queue head |
| rq_lk_tag | output | 6 | Tag on eviction lookup port |
| rq_lk_set | output | 6 | Set on eviction lookup port |
| rq_lk_hit | input | 1 | Eviction address found in table |
| rq_lk_idx | input | 3 | Table index for eviction lookup |
| rq_pop | output | 1 | Dequeue eviction queue head |
| rsp_valid | input | 1 | Network response present |
| rsp_addr | input | 16 | Response address |
| rsp_kind | input | 3 | Response message type |
| rsp_origin | input | 4 | Response sender id |
| rsp_lk_tag | output | 6 | Tag on response lookup port |
| rsp_lk_set | output | 6 | Set on response lookup port |
| rsp_lk_hit | input | 1 | Response address found in table |
| rsp_lk_idx | input | 3 | Table index for response lookup |
| rsp_pop | output | 1 | Consume network response |
| req_valid | input | 1 | Network request present |
| req_addr | input | 16 | Request address |
| req_kind | input | 3 | Request message type |
| req_origin | input | 4 | Request sender id |
| req_lk_tag | output | 6 | Tag on request lookup port |
| req_lk_set | output | 6 | Set on request lookup port |
| req_lk_hit | input | 1 | Request address found in table |
| req_lk_idx | input | 3 | Table index for request lookup |
| req_lk_entry_valid | input | 1 | Valid bit of the hit table entry |
| proto_stall | input | 1 | Protocol table asks to hold the request |
| req_pop | output | 1 | Consume network request |
| tbl_full | input | 1 | Pending-transaction table full |
| s2_busy | input | 1 | Stage 2 pending |
| s3_busy | input | 1 | Stage 3 pending |
| fwd_net_ready | input | 1 | Forwarded-request network output can accept |
| rsp_net_ready | input | 1 | Response network output can accept |
| grant | output | 3 | One-hot winner: bit0 eviction, bit1 response, bit2 request |
| s2_valid | output | 1 | Stage-2 register holds a message |
| s2_src | output | 2 | Source code of stage-2 message |
| s2_addr | output | 16 | Stage-2 address |
| s2_kind | output | 3 | Stage-2 message type |
| s2_origin | output | 4 | Stage-2 sender id |
| s2_tbl_hit | output | 1 | Winner's lookup hit flag |
| s2_tbl_idx | output | 3 | Winner's table index, 0 on miss |

## Verification
The assertions assume that every input is a known two-state value that is stable between rising edges. They also assume that the busy flags describe the later stages, so that blocking on them is always legal. The checks tie fullness, busy and occupancy to the absence of eviction and request grants, and tie any grant to a valid stage-2 register one cycle later. The stimulus drives every input only on the falling edge, with no unknown values. It mixes directed cases aimed at each admission rule with a long run of biased random cycles in which fullness, busy, readiness, hit and stall vary independently.

// File: rtl/coh_issue_pkg.sv
package coh_issue_pkg;
    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        SRC_EVICT = 2'd0,
        SRC_RESP  = 2'd1,
        SRC_REQ   = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;
endpackage

// File: rtl/coh_issue_split.sv
module coh_issue_split #(
    parameter int NPORT  = 3,
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 4,
    parameter int SET_W  = 6,
    localparam int TAG_W = ADDR_W - SET_W - OFS_W
) (
    input  logic [NPORT-1:0][ADDR_W-1:0] addr,
    output logic [NPORT-1:0][TAG_W-1:0]  tag,
    output logic [NPORT-1:0][SET_W-1:0]  set
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign tag[p] = addr[p][ADDR_W-1 -: TAG_W];
        assign set[p] = addr[p][OFS_W +: SET_W];
    end
endmodule

// File: rtl/coh_issue_elig.sv
module coh_issue_elig
    import coh_issue_pkg::*;
(
    input  logic            rq_empty,
    input  logic            rq_hit,
    input  logic            rsp_valid,
    input  logic            req_valid,
    input  logic            req_hit,
    input  logic            req_entry_valid,
    input  logic            proto_stall,
    input  logic            tbl_full,
    input  logic            occupied,
    input  logic            fwd_ready,
    input  logic            rsp_ready,
    output logic [NSRC-1:0] elig
);
    logic common_ok;
    logic req_tbl_ok;

    always_comb begin
        common_ok  = !tbl_full && !occupied && fwd_ready && rsp_ready;
        req_tbl_ok = !req_hit || !req_entry_valid || !proto_stall;
        elig                 = '0;
        elig[int'(SRC_EVICT)] = !rq_empty && !rq_hit && common_ok;
        elig[int'(SRC_RESP)]  = rsp_valid;
        elig[int'(SRC_REQ)]   = req_valid && req_tbl_ok && common_ok;
    end
endmodule

// File: rtl/coh_issue_prio.sv
module coh_issue_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] elig,
    output logic [N-1:0] grant
);
    logic [N:0] taken;
    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign grant[i]   = elig[i] && !taken[i];
        assign taken[i+1] = taken[i] || elig[i];
    end
endmodule

// File: rtl/coh_issue_sched.sv
module coh_issue_sched
    import coh_issue_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OFS_W     = 4,
    parameter int SET_W     = 6,
    parameter int KIND_W    = 3,
    parameter int ORG_W     = 4,
    parameter int TBL_DEPTH = 8,
    localparam int TAG_W    = ADDR_W - SET_W - OFS_W,
    localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rq_empty,
    input  logic [ADDR_W-1:0] rq_addr,
    output logic [TAG_W-1:0]  rq_lk_tag,
    output logic [SET_W-1:0]  rq_lk_set,
    input  logic              rq_lk_hit,
    input  logic [IDX_W-1:0]  rq_lk_idx,
    output logic              rq_pop,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [KIND_W-1:0] rsp_kind,
    input  logic [ORG_W-1:0]  rsp_origin,
    output logic [TAG_W-1:0]  rsp_lk_tag,
    output logic [SET_W-1:0]  rsp_lk_set,
    input  logic              rsp_lk_hit,
    input  logic [IDX_W-1:0]  rsp_lk_idx,
    output logic              rsp_pop,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ORG_W-1:0]  req_origin,
    output logic [TAG_W-1:0]  req_lk_tag,
    output logic [SET_W-1:0]  req_lk_set,
    input  logic              req_lk_hit,
    input  logic [IDX_W-1:0]  req_lk_idx,
    input  logic              req_lk_entry_valid,
    input  logic              proto_stall,
    output logic              req_pop,
    input  logic              tbl_full,
    input  logic              s2_busy,
    input  logic              s3_busy,
    input  logic              fwd_net_ready,
    input  logic              rsp_net_ready,
    output logic [2:0]        grant,
    output logic              s2_valid,
    output logic [1:0]        s2_src,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [KIND_W-1:0] s2_kind,
    output logic [ORG_W-1:0]  s2_origin,
    output logic              s2_tbl_hit,
    output logic [IDX_W-1:0]  s2_tbl_idx
);
    typedef struct packed {
        logic              valid;
        src_e              src;
        logic [ADDR_W-1:0] addr;
        logic [KIND_W-1:0] kind;
        logic [ORG_W-1:0]  origin;
        logic              tbl_hit;
        logic [IDX_W-1:0]  tbl_idx;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [NSRC-1:0][ADDR_W-1:0] port_addr;
    logic [NSRC-1:0][TAG_W-1:0]  port_tag;
    logic [NSRC-1:0][SET_W-1:0]  port_set;
    logic [NSRC-1:0]             elig;
    logic [NSRC-1:0]             win;
    logic                        occupied;

    assign port_addr[int'(SRC_EVICT)] = rq_addr;
    assign port_addr[int'(SRC_RESP)]  = rsp_addr;
    assign port_addr[int'(SRC_REQ)]   = req_addr;

    coh_issue_split #(
        .NPORT (NSRC),
        .ADDR_W(ADDR_W),
        .OFS_W (OFS_W),
        .SET_W (SET_W)
    ) u_split (
        .addr(port_addr),
        .tag (port_tag),
        .set (port_set)
    );

    assign rq_lk_tag  = port_tag[int'(SRC_EVICT)];
    assign rq_lk_set  = port_set[int'(SRC_EVICT)];
    assign rsp_lk_tag = port_tag[int'(SRC_RESP)];
    assign rsp_lk_set = port_set[int'(SRC_RESP)];
    assign req_lk_tag = port_tag[int'(SRC_REQ)];
    assign req_lk_set = port_set[int'(SRC_REQ)];

    assign occupied = stage_q.valid || s2_busy || s3_busy;

    coh_issue_elig u_elig (
        .rq_empty       (rq_empty),
        .rq_hit         (rq_lk_hit),
        .rsp_valid      (rsp_valid),
        .req_valid      (req_valid),
        .req_hit        (req_lk_hit),
        .req_entry_valid(req_lk_entry_valid),
        .proto_stall    (proto_stall),
        .tbl_full       (tbl_full),
        .occupied       (occupied),
        .fwd_ready      (fwd_net_ready),
        .rsp_ready      (rsp_net_ready),
        .elig           (elig)
    );

    coh_issue_prio #(.N(NSRC)) u_prio (
        .elig (elig),
        .grant(win)
    );

    assign grant   = win;
    assign rq_pop  = win[int'(SRC_EVICT)];
    assign rsp_pop = win[int'(SRC_RESP)];
    assign req_pop = win[int'(SRC_REQ)];

    always_comb begin
        stage_d = '0;
        stage_d.src = SRC_NONE;
        unique case (1'b1)
            win[int'(SRC_EVICT)]: begin
                stage_d.valid   = 1'b1;
                stage_d.src     = SRC_EVICT;
                stage_d.addr    = rq_addr;
                stage_d.tbl_hit = rq_lk_hit;
                stage_d.tbl_idx = rq_lk_hit ? rq_lk_idx : '0;
            end
            win[int'(SRC_RESP)]: begin
                stage_d.valid   = 1'b1;
                stage_d.src     = SRC_RESP;
                stage_d.addr    = rsp_addr;
                stage_d.kind    = rsp_kind;
                stage_d.origin  = rsp_origin;
                stage_d.tbl_hit = rsp_lk_hit;
                stage_d.tbl_idx = rsp_lk_hit ? rsp_lk_idx : '0;
            end
            win[int'(SRC_REQ)]: begin
                stage_d.valid   = 1'b1;
                stage_d.src     = SRC_REQ;
                stage_d.addr    = req_addr;
                stage_d.kind    = req_kind;
                stage_d.origin  = req_origin;
                stage_d.tbl_hit = req_lk_hit;
                stage_d.tbl_idx = req_lk_hit ? req_lk_idx : '0;
            end
            default: ;
        endcase
        if (!stage_d.valid) begin
            stage_d.src = SRC_EVICT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign s2_valid   = stage_q.valid;
    assign s2_src     = stage_q.src;
    assign s2_addr    = stage_q.addr;
    assign s2_kind    = stage_q.kind;
    assign s2_origin  = stage_q.origin;
    assign s2_tbl_hit = stage_q.tbl_hit;
    assign s2_tbl_idx = stage_q.tbl_idx;
endmodule

// File: rtl/coh_issue_sched_chk.sv
module coh_issue_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] grant,
    input logic       rq_empty,
    input logic       rsp_valid,
    input logic       req_valid,
    input logic       tbl_full,
    input logic       s2_busy,
    input logic       s3_busy,
    input logic       fwd_net_ready,
    input logic       rsp_net_ready,
    input logic       s2_valid
);
    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_empty && !rsp_valid && !req_valid) |-> (grant == 3'b000));

    p_evict_needs_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rq_empty |-> !grant[0]);

    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_full |-> (!grant[0] && !grant[2]));

    p_net_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_net_ready || !rsp_net_ready) |-> (!grant[0] && !grant[2]));

    p_resp_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rq_empty) |-> grant[1]);

    p_req_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !grant[2]);

    p_stage_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 3'b000) |=> s2_valid);

    p_stage_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 3'b000) |=> !s2_valid);

    p_single_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid || s2_busy || s3_busy) |-> (!grant[0] && !grant[2]));
endmodule

bind coh_issue_sched coh_issue_sched_chk u_chk (.*);

// File: tb/coh_issue_sched_test.sv
`timescale 1ns/1ps
module coh_issue_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rq_empty = 1'b1;
    logic [15:0] rq_addr = '0;
    logic        rq_lk_hit = 1'b0;
    logic [2:0]  rq_lk_idx = '0;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_addr = '0;
    logic [2:0]  rsp_kind = '0;
    logic [3:0]  rsp_origin = '0;
    logic        rsp_lk_hit = 1'b0;
    logic [2:0]  rsp_lk_idx = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_kind = '0;
    logic [3:0]  req_origin = '0;
    logic        req_lk_hit = 1'b0;
    logic [2:0]  req_lk_idx = '0;
    logic        req_lk_entry_valid = 1'b0;
    logic        proto_stall = 1'b0;
    logic        tbl_full = 1'b0;
    logic        s2_busy = 1'b0;
    logic        s3_busy = 1'b0;
    logic        fwd_net_ready = 1'b1;
    logic        rsp_net_ready = 1'b1;

    logic [5:0]  rq_lk_tag, rq_lk_set, rsp_lk_tag, rsp_lk_set, req_lk_tag, req_lk_set;
    logic        rq_pop, rsp_pop, req_pop;
    logic [2:0]  grant;
    logic        s2_valid;
    logic [1:0]  s2_src;
    logic [15:0] s2_addr;
    logic [2:0]  s2_kind;
    logic [3:0]  s2_origin;
    logic        s2_tbl_hit;
    logic [2:0]  s2_tbl_idx;

    int total = 0;
    int bad = 0;

    int m_v = 0, m_src = 0, m_addr = 0, m_kind = 0, m_org = 0, m_hit = 0, m_idx = 0;

    always #2.5 clk = ~clk;

    coh_issue_sched uut (
        .clk(clk), .rst_n(rst_n),
        .rq_empty(rq_empty), .rq_addr(rq_addr), .rq_lk_tag(rq_lk_tag), .rq_lk_set(rq_lk_set),
        .rq_lk_hit(rq_lk_hit), .rq_lk_idx(rq_lk_idx), .rq_pop(rq_pop),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind), .rsp_origin(rsp_origin),
        .rsp_lk_tag(rsp_lk_tag), .rsp_lk_set(rsp_lk_set), .rsp_lk_hit(rsp_lk_hit),
        .rsp_lk_idx(rsp_lk_idx), .rsp_pop(rsp_pop),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind), .req_origin(req_origin),
        .req_lk_tag(req_lk_tag), .req_lk_set(req_lk_set), .req_lk_hit(req_lk_hit),
        .req_lk_idx(req_lk_idx), .req_lk_entry_valid(req_lk_entry_valid),
        .proto_stall(proto_stall), .req_pop(req_pop),
        .tbl_full(tbl_full), .s2_busy(s2_busy), .s3_busy(s3_busy),
        .fwd_net_ready(fwd_net_ready), .rsp_net_ready(rsp_net_ready),
        .grant(grant), .s2_valid(s2_valid), .s2_src(s2_src), .s2_addr(s2_addr),
        .s2_kind(s2_kind), .s2_origin(s2_origin), .s2_tbl_hit(s2_tbl_hit), .s2_tbl_idx(s2_tbl_idx)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        rq_empty = 1'b1; rq_lk_hit = 1'b0; rsp_valid = 1'b0; req_valid = 1'b0;
        rsp_lk_hit = 1'b0; req_lk_hit = 1'b0; req_lk_entry_valid = 1'b0; proto_stall = 1'b0;
        tbl_full = 1'b0; s2_busy = 1'b0; s3_busy = 1'b0;
        fwd_net_ready = 1'b1; rsp_net_ready = 1'b1;
    endtask

    // Called at a falling edge with inputs already set; leaves at the next falling edge.
    task automatic step(input string tag);
        bit ok_evict, ok_resp, ok_req, busy;
        int win, exp_grant;
        #1;
        busy      = (m_v != 0) || s2_busy || s3_busy;
        ok_evict  = !rq_empty && !tbl_full && !rq_lk_hit && !busy && fwd_net_ready && rsp_net_ready;
        ok_resp   = rsp_valid;
        ok_req    = req_valid && !tbl_full && !busy && fwd_net_ready && rsp_net_ready &&
                    (!req_lk_hit || !req_lk_entry_valid || !proto_stall);
        if (ok_evict)     win = 0;
        else if (ok_resp) win = 1;
        else if (ok_req)  win = 2;
        else              win = -1;
        exp_grant = (win < 0) ? 0 : (1 << win);
        chk(tag, "grant", int'(grant), exp_grant);
        chk(tag, "rq_pop", int'(rq_pop), int'(win == 0));
        chk(tag, "rsp_pop", int'(rsp_pop), int'(win == 1));
        chk(tag, "req_pop", int'(req_pop), int'(win == 2));
        chk({tag, " R10"}, "rq_tag", int'(rq_lk_tag), int'(rq_addr) / 1024);
        chk({tag, " R10"}, "rq_set", int'(rq_lk_set), (int'(rq_addr) / 16) % 64);
        chk({tag, " R10"}, "rsp_tag", int'(rsp_lk_tag), int'(rsp_addr) / 1024);
        chk({tag, " R10"}, "req_set", int'(req_lk_set), (int'(req_addr) / 16) % 64);
        chk({tag, " R8"}, "s2_valid", int'(s2_valid), m_v);
        chk({tag, " R8"}, "s2_src", int'(s2_src), m_src);
        chk({tag, " R8"}, "s2_addr", int'(s2_addr), m_addr);
        chk({tag, " R8"}, "s2_kind", int'(s2_kind), m_kind);
        chk({tag, " R8"}, "s2_origin", int'(s2_origin), m_org);
        chk({tag, " R11"}, "s2_tbl_hit", int'(s2_tbl_hit), m_hit);
        chk({tag, " R11"}, "s2_tbl_idx", int'(s2_tbl_idx), m_idx);
        @(posedge clk);
        m_v = 0; m_src = 0; m_addr = 0; m_kind = 0; m_org = 0; m_hit = 0; m_idx = 0;
        if (win == 0) begin
            m_v = 1; m_src = 0; m_addr = int'(rq_addr);
            m_hit = int'(rq_lk_hit); m_idx = rq_lk_hit ? int'(rq_lk_idx) : 0;
        end else if (win == 1) begin
            m_v = 1; m_src = 1; m_addr = int'(rsp_addr); m_kind = int'(rsp_kind);
            m_org = int'(rsp_origin);
            m_hit = int'(rsp_lk_hit); m_idx = rsp_lk_hit ? int'(rsp_lk_idx) : 0;
        end else if (win == 2) begin
            m_v = 1; m_src = 2; m_addr = int'(req_addr); m_kind = int'(req_kind);
            m_org = int'(req_origin);
            m_hit = int'(req_lk_hit); m_idx = req_lk_hit ? int'(req_lk_idx) : 0;
        end
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rq_addr = 16'hA5C3; rsp_addr = 16'h3F10; req_addr = 16'h7E28;
        rsp_kind = 3'd5; rsp_origin = 4'd9; req_kind = 3'd2; req_origin = 4'd6;
        rq_lk_idx = 3'd3; rsp_lk_idx = 3'd5; req_lk_idx = 3'd6;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 idle after reset");

        rq_empty = 1'b0;
        step("R2 eviction admitted");
        step("R9 occupied by previous winner");
        idle_inputs(); step("R8 drain");

        rq_empty = 1'b0; rq_lk_hit = 1'b1;
        step("R2 eviction blocked by table hit");

        idle_inputs(); req_valid = 1'b1; fwd_net_ready = 1'b0;
        step("R3 request blocked by network");
        fwd_net_ready = 1'b1; s3_busy = 1'b1;
        step("R9 request blocked by stage 3");

        idle_inputs(); req_valid = 1'b1; req_lk_hit = 1'b1; req_lk_entry_valid = 1'b1;
        proto_stall = 1'b1;
        step("R4 stalled hit on valid entry");
        req_lk_entry_valid = 1'b0;
        step("R4 hit on invalid entry admitted");
        idle_inputs(); step("R8 drain");

        rsp_valid = 1'b1; tbl_full = 1'b1; s2_busy = 1'b1; rsp_net_ready = 1'b0;
        step("R5 response ignores blockers");
        idle_inputs(); rsp_valid = 1'b1; rsp_lk_hit = 1'b0;
        step("R11 response miss");
        idle_inputs(); step("R8 drain");

        rq_empty = 1'b0; rsp_valid = 1'b1; req_valid = 1'b1;
        step("R6 eviction first");
        idle_inputs(); step("R8 drain");
        rsp_valid = 1'b1; req_valid = 1'b1; rsp_lk_hit = 1'b1;
        step("R6 response before request");
        idle_inputs(); step("R7 nothing admissible");

        for (int n = 0; n < 3000; n++) begin
            rq_empty           = ($urandom_range(0, 1) == 0);
            rq_lk_hit          = ($urandom_range(0, 4) == 0);
            rsp_valid          = ($urandom_range(0, 3) == 0);
            req_valid          = ($urandom_range(0, 1) == 0);
            rsp_lk_hit         = ($urandom_range(0, 1) == 0);
            req_lk_hit         = ($urandom_range(0, 1) == 0);
            req_lk_entry_valid = ($urandom_range(0, 1) == 0);
            proto_stall        = ($urandom_range(0, 1) == 0);
            tbl_full           = ($urandom_range(0, 6) == 0);
            s2_busy            = ($urandom_range(0, 6) == 0);
            s3_busy            = ($urandom_range(0, 6) == 0);
            fwd_net_ready      = ($urandom_range(0, 7) != 0);
            rsp_net_ready      = ($urandom_range(0, 7) != 0);
            rq_addr    = 16'($urandom); rsp_addr = 16'($urandom); req_addr = 16'($urandom);
            rsp_kind   = 3'($urandom); req_kind = 3'($urandom);
            rsp_origin = 4'($urandom); req_origin = 4'($urandom);
            rq_lk_idx  = 3'($urandom); rsp_lk_idx = 3'($urandom); req_lk_idx = 3'($urandom);
            step("R6 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule